// File: doc/BRIEF.md
# Single-Beat External Bus Master with Retry

This block connects an internal requester to a shared, synchronous external bus and carries out one single-beat transfer at a time, up to four bytes wide. A request is latched when the block is idle. The block then asks for the bus, waits until it is granted and the bus is free, and presents the address and the transfer attributes for one clock. It then waits in the data phase until a slave ends the cycle. Every output is decoded from registers and every input is sampled on the rising clock edge.

The retry line works in both directions. When a slave pulls it low during the data phase, the block lets go of the bus and competes for it again. It then repeats the same transfer with the same address, attributes and write data, and reports nothing to the requester until the cycle ends properly. When a new internal request arrives while another master is holding the bus, the block pulls retry low for one clock so that the other master backs off. The address, attribute, data and retry lines are released (high impedance) whenever the block neither owns the bus nor drives that pulse.

Top module: `ext_bus_master`

## Requirements
- R1: After reset, bus_req_n and addr_strobe_n are 1, req_ready is 1 and rsp_valid is 0. The block does not drive retry, which reads high through the bus pull-up.
- R2: After a request is accepted, bus_req_n goes low on the next clock. The address phase shows addr_strobe_n low for exactly one clock and is followed by the data phase.
- R3: The address phase starts only after an edge at which bus_grant_n is 0 and bus_busy_n is 1. A grant while bus_busy_n is 0 does not start it.
- R4: During the address phase, bus_addr carries the request address, bus_rw carries the direction (1 = write, 0 = read) and bus_size carries the size code (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes), all unchanged. For a write, bus_data carries the write data.
- R5: If retry is sampled low in the data phase while xfer_err_n is high, the block releases the bus, drives bus_req_n low on the next clock and gives no response. It then re-runs the cycle with the same address, attributes and write data.
- R6: If a request is accepted while bus_busy_n is 0, bus_retry_n is driven low for exactly the one clock that follows acceptance. A request accepted while the bus is free produces no such pulse.
- R7: If xfer_err_n is sampled low in the data phase, the next clock shows a one-clock rsp_valid with rsp_err = 1 and the cycle is not retried. This holds even when retry is low on the same edge.
- R8: If xfer_ack_n is sampled low in the data phase while retry and xfer_err_n are high, the next clock shows a one-clock rsp_valid with rsp_err = 0. rsp_rdata then holds the bus_data value sampled on that edge.
- R9: Request inputs are ignored while req_ready is 0. A request offered during a transfer starts no second transfer and does not alter the address on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Internal request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | SIZE_W | Size code of the beat |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Block idle; request taken on this edge |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Completion ended by transfer error |
| rsp_rdata | output | DATA_W | Read data of the completed cycle |
| bus_req_n | output | 1 | Bus request, active low |
| bus_grant_n | input | 1 | Bus grant, active low |
| bus_busy_n | input | 1 | Bus in use by some master, active low |
| addr_strobe_n | output | 1 | Address phase marker, active low |
| bus_addr | output | ADDR_W | Address, tri-state |
| bus_rw | output | 1 | Direction attribute, tri-state |
| bus_size | output | SIZE_W | Size attribute, tri-state |
| bus_data | inout | DATA_W | Data lines, tri-state |
| xfer_ack_n | input | 1 | Transfer acknowledge, active low |
| xfer_err_n | input | 1 | Transfer error, active low |
| bus_retry_n | inout | 1 | Retry, active low, both directions |

## Verification
The bench builds the block with its default widths: a 32-bit address, a 32-bit data beat and a 2-bit size code. At these widths a full four-byte beat, all three size codes and addresses with the top bit set can be checked on the pins. One table-driven loop runs reads and writes with grant delays of zero to several clocks, ending in acknowledge, error, retry followed by acknowledge, or retry and error together. Directed tests cover reset, a grant while the bus is busy, the one-clock eviction pulse, and a request offered in the middle of a transfer.

// File: rtl/ebm_pkg.sv
package ebm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARB  = 2'd1,
        ST_ADDR = 2'd2,
        ST_DATA = 2'd3
    } ebm_state_e;
endpackage

// File: rtl/ebm_ctrl.sv
module ebm_ctrl
    import ebm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SIZE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              grant_n,
    input  logic              busy_n,
    input  logic              ack_n,
    input  logic              err_n,
    input  logic              retry_in_n,
    input  logic [DATA_W-1:0] data_in,
    output logic              idle,
    output logic              req_n,
    output logic              strobe_n,
    output logic              own,
    output logic              kick,
    output logic              hold_write,
    output logic [SIZE_W-1:0] hold_size,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [DATA_W-1:0] hold_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);
    typedef struct packed {
        ebm_state_e        st;
        logic              kick;
        logic              wr;
        logic [SIZE_W-1:0] sz;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              rsp_v;
        logic              rsp_e;
        logic [DATA_W-1:0] rdata;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.kick  = 1'b0;
        r_d.rsp_v = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st    = ST_ARB;
                    r_d.wr    = req_write;
                    r_d.sz    = req_size;
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    // another master holds the bus as this access starts
                    r_d.kick  = !busy_n;
                end
            end
            ST_ARB: begin
                if (!grant_n && busy_n) r_d.st = ST_ADDR;
            end
            ST_ADDR: r_d.st = ST_DATA;
            ST_DATA: begin
                if (!err_n) begin
                    r_d.st    = ST_IDLE;
                    r_d.rsp_v = 1'b1;
                    r_d.rsp_e = 1'b1;
                    r_d.rdata = '0;
                end else if (!retry_in_n) begin
                    r_d.st = ST_ARB;
                end else if (!ack_n) begin
                    r_d.st    = ST_IDLE;
                    r_d.rsp_v = 1'b1;
                    r_d.rsp_e = 1'b0;
                    r_d.rdata = data_in;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign idle       = (r_q.st == ST_IDLE);
    assign req_n      = (r_q.st != ST_ARB);
    assign strobe_n   = (r_q.st != ST_ADDR);
    assign own        = (r_q.st == ST_ADDR) || (r_q.st == ST_DATA);
    assign kick       = r_q.kick;
    assign hold_write = r_q.wr;
    assign hold_size  = r_q.sz;
    assign hold_addr  = r_q.addr;
    assign hold_wdata = r_q.wdata;
    assign rsp_valid  = r_q.rsp_v;
    assign rsp_err    = r_q.rsp_e;
    assign rsp_rdata  = r_q.rdata;
endmodule

// File: rtl/ebm_pins.sv
module ebm_pins #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SIZE_W = 2
) (
    input  logic              own,
    input  logic              kick,
    input  logic              write,
    input  logic [SIZE_W-1:0] size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] pin_addr,
    output logic              pin_rw,
    output logic [SIZE_W-1:0] pin_size,
    inout  wire  [DATA_W-1:0] pin_data,
    inout  wire               pin_retry_n,
    output logic [DATA_W-1:0] data_in,
    output logic              retry_in_n
);
    assign pin_addr    = own ? addr : {ADDR_W{1'bz}};
    assign pin_rw      = own ? write : 1'bz;
    assign pin_size    = own ? size : {SIZE_W{1'bz}};
    assign pin_data    = (own && write) ? wdata : {DATA_W{1'bz}};
    assign pin_retry_n = kick ? 1'b0 : 1'bz;
    assign data_in     = pin_data;
    assign retry_in_n  = pin_retry_n;
endmodule

// File: rtl/ext_bus_master.sv
module ext_bus_master #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SIZE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_req_n,
    input  logic              bus_grant_n,
    input  logic              bus_busy_n,
    output logic              addr_strobe_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rw,
    output logic [SIZE_W-1:0] bus_size,
    inout  wire  [DATA_W-1:0] bus_data,
    input  logic              xfer_ack_n,
    input  logic              xfer_err_n,
    inout  wire               bus_retry_n
);
    logic              own_w, kick_w, hold_wr_w, retry_in_w;
    logic [SIZE_W-1:0] hold_sz_w;
    logic [ADDR_W-1:0] hold_addr_w;
    logic [DATA_W-1:0] hold_wdata_w, data_in_w;

    ebm_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_size   (req_size),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .grant_n    (bus_grant_n),
        .busy_n     (bus_busy_n),
        .ack_n      (xfer_ack_n),
        .err_n      (xfer_err_n),
        .retry_in_n (retry_in_w),
        .data_in    (data_in_w),
        .idle       (req_ready),
        .req_n      (bus_req_n),
        .strobe_n   (addr_strobe_n),
        .own        (own_w),
        .kick       (kick_w),
        .hold_write (hold_wr_w),
        .hold_size  (hold_sz_w),
        .hold_addr  (hold_addr_w),
        .hold_wdata (hold_wdata_w),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err),
        .rsp_rdata  (rsp_rdata)
    );

    ebm_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_pins (
        .own         (own_w),
        .kick        (kick_w),
        .write       (hold_wr_w),
        .size        (hold_sz_w),
        .addr        (hold_addr_w),
        .wdata       (hold_wdata_w),
        .pin_addr    (bus_addr),
        .pin_rw      (bus_rw),
        .pin_size    (bus_size),
        .pin_data    (bus_data),
        .pin_retry_n (bus_retry_n),
        .data_in     (data_in_w),
        .retry_in_n  (retry_in_w)
    );
endmodule

// File: rtl/ebm_sva.sv
module ebm_sva #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              bus_req_n,
    input logic              bus_grant_n,
    input logic              bus_busy_n,
    input logic              addr_strobe_n,
    input logic              xfer_ack_n,
    input logic              xfer_err_n,
    input logic              retry_in_n,
    input logic              own,
    input logic              kick,
    input logic [ADDR_W-1:0] hold_addr,
    input logic              rsp_valid,
    input logic              rsp_err
);
    logic in_data;
    assign in_data = own && addr_strobe_n;

    // R2: address phase directly follows arbitration
    p_addr_after_arb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_strobe_n) |-> $past(!bus_req_n));
    // R2: strobe lasts one clock and hands over to the data phase
    p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_strobe_n |=> (addr_strobe_n && own));
    // R3: start only on grant with free bus
    p_start_on_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_strobe_n) |-> $past(!bus_grant_n && bus_busy_n));
    // R5: transfer attributes held across the whole transaction
    p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(hold_addr));
    // R5: retry drops ownership and re-arbitrates without a response
    p_retry_rearb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && xfer_err_n && !retry_in_n) |=> (!bus_req_n && !own && !rsp_valid));
    // R6: eviction pulse lasts one clock
    p_kick_one_clock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !kick);
    // R6: eviction pulse never while owning the bus
    p_kick_not_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        kick |-> !own);
    // R7: error ends the cycle without retry
    p_err_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && !xfer_err_n) |=> (rsp_valid && rsp_err && bus_req_n));
    // R8: acknowledge completes cleanly
    p_ack_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && xfer_err_n && retry_in_n && !xfer_ack_n) |=> (rsp_valid && !rsp_err));
    // R8: response is a single-clock pulse
    p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

bind ext_bus_master ebm_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .bus_req_n     (bus_req_n),
    .bus_grant_n   (bus_grant_n),
    .bus_busy_n    (bus_busy_n),
    .addr_strobe_n (addr_strobe_n),
    .xfer_ack_n    (xfer_ack_n),
    .xfer_err_n    (xfer_err_n),
    .retry_in_n    (retry_in_w),
    .own           (own_w),
    .kick          (kick_w),
    .hold_addr     (hold_addr_w),
    .rsp_valid     (rsp_valid),
    .rsp_err       (rsp_err)
);

// File: tb/ext_bus_master_tb.sv
`timescale 1ns/1ps
module ext_bus_master_tb;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int SW = 2;

    typedef struct packed {
        logic          wr;
        logic [SW-1:0] sz;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic [2:0]    gdly;
        logic [1:0]    term;   // 0 ack, 1 error, 2 retry then ack, 3 retry+error
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd2, 32'h1000_0040, 32'hDEAD_BEEF, 32'h0, 3'd0, 2'd0},
        '{1'b0, 2'd2, 32'h8000_0100, 32'h0, 32'hCAFE_F00D, 3'd2, 2'd0},
        '{1'b0, 2'd0, 32'h0000_0003, 32'h0, 32'h0000_00A5, 3'd1, 2'd2},
        '{1'b1, 2'd1, 32'h2222_0002, 32'h0000_5A5A, 32'h0, 3'd3, 2'd2},
        '{1'b0, 2'd2, 32'hFFFF_FFFC, 32'h0, 32'h1234_5678, 3'd0, 2'd1},
        '{1'b1, 2'd0, 32'h0000_0010, 32'h0000_0077, 32'h0, 3'd1, 2'd3},
        '{1'b0, 2'd1, 32'h4000_0006, 32'h0, 32'h0000_9ABC, 3'd4, 2'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [SW-1:0] req_size = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, rsp_err, bus_req_n, addr_strobe_n;
    logic [DW-1:0] rsp_rdata;
    logic bus_grant_n = 1'b1, bus_busy_n = 1'b1, xfer_ack_n = 1'b1, xfer_err_n = 1'b1;
    logic [AW-1:0] bus_addr;
    logic bus_rw;
    logic [SW-1:0] bus_size;
    wire [DW-1:0] bus_data;
    wire bus_retry_n;
    logic dd_en = 1'b0, rt_en = 1'b0;
    logic [DW-1:0] dd_val = '0;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    assign bus_data    = dd_en ? dd_val : {DW{1'bz}};
    assign bus_retry_n = rt_en ? 1'b0 : 1'bz;
    pullup (bus_retry_n);

    always #2 clk = ~clk;

    ext_bus_master #(.ADDR_W(AW), .DATA_W(DW), .SIZE_W(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .bus_req_n(bus_req_n), .bus_grant_n(bus_grant_n),
        .bus_busy_n(bus_busy_n), .addr_strobe_n(addr_strobe_n), .bus_addr(bus_addr),
        .bus_rw(bus_rw), .bus_size(bus_size), .bus_data(bus_data),
        .xfer_ack_n(xfer_ack_n), .xfer_err_n(xfer_err_n), .bus_retry_n(bus_retry_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic wr, input logic [SW-1:0] sz, input logic [AW-1:0] a, input logic [DW-1:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(bus_req_n == 1'b0, "R2 request after accept", 64'(bus_req_n), 64'd0);
    endtask

    // grant after gdly clocks, then check the address phase
    task automatic arb_and_addr(input vec_t v, input string tag);
        for (int i = 0; i < int'(v.gdly); i++) begin
            @(negedge clk);
            chk(addr_strobe_n == 1'b1, "R3 no address phase before grant", 64'(addr_strobe_n), 64'd1);
        end
        bus_grant_n = 1'b0;
        @(negedge clk);
        bus_grant_n = 1'b1;
        chk(addr_strobe_n == 1'b0, "R2 address strobe", 64'(addr_strobe_n), 64'd0);
        chk(bus_addr === v.addr, {tag, " address"}, 64'(bus_addr), 64'(v.addr));
        chk(bus_rw === v.wr && bus_size === v.sz, {tag, " attributes"},
            64'({bus_rw, bus_size}), 64'({v.wr, v.sz}));
        if (v.wr) chk(bus_data === v.wdata, {tag, " write data"}, 64'(bus_data), 64'(v.wdata));
        @(negedge clk);
        chk(addr_strobe_n == 1'b1, "R2 strobe one clock", 64'(addr_strobe_n), 64'd1);
    endtask

    task automatic run_vec(input vec_t v);
        issue(v.wr, v.sz, v.addr, v.wdata);
        chk(bus_retry_n === 1'b1, "R6 no pulse with free bus", 64'(bus_retry_n), 64'd1);
        arb_and_addr(v, "R4");
        if (v.term == 2'd2) begin
            rt_en = 1'b1;
            @(negedge clk);
            rt_en = 1'b0;
            chk(bus_req_n == 1'b0 && rsp_valid == 1'b0, "R5 re-arbitrate silently",
                64'({bus_req_n, rsp_valid}), 64'd0);
            arb_and_addr(v, "R5 replay");
        end
        if (v.term == 2'd1 || v.term == 2'd3) begin
            xfer_err_n = 1'b0;
            rt_en = (v.term == 2'd3);
        end else begin
            xfer_ack_n = 1'b0;
            if (!v.wr) begin dd_en = 1'b1; dd_val = v.rdata; end
        end
        @(negedge clk);
        xfer_err_n = 1'b1; xfer_ack_n = 1'b1; rt_en = 1'b0; dd_en = 1'b0;
        if (v.term[0]) begin
            chk(rsp_valid && rsp_err, "R7 error response", 64'({rsp_valid, rsp_err}), 64'd3);
        end else begin
            chk(rsp_valid && !rsp_err, "R8 ack response", 64'({rsp_valid, rsp_err}), 64'd2);
            if (!v.wr) chk(rsp_rdata == v.rdata, "R8 read data", 64'(rsp_rdata), 64'(v.rdata));
        end
        @(negedge clk);
        chk(!rsp_valid && bus_req_n, "R7 R8 single pulse, no retry", 64'({rsp_valid, bus_req_n}), 64'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R2 act=hung exp=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        vec_t dv;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(bus_req_n && addr_strobe_n && req_ready && !rsp_valid, "R1 reset outputs",
            64'({bus_req_n, addr_strobe_n, req_ready, rsp_valid}), 64'he);
        chk(bus_retry_n === 1'b1, "R1 retry released", 64'(bus_retry_n), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && bus_req_n, "R1 idle after reset", 64'({req_ready, bus_req_n}), 64'd3);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R6 / R3: external master holds the bus when request starts
        bus_busy_n = 1'b0;
        issue(1'b0, 2'd2, 32'h0ABC_0000, 32'h0);
        chk(bus_retry_n === 1'b0, "R6 eviction pulse", 64'(bus_retry_n), 64'd0);
        bus_grant_n = 1'b0;
        @(negedge clk);
        chk(bus_retry_n === 1'b1, "R6 pulse one clock", 64'(bus_retry_n), 64'd1);
        chk(addr_strobe_n == 1'b1, "R3 grant while busy", 64'(addr_strobe_n), 64'd1);
        @(negedge clk);
        chk(addr_strobe_n == 1'b1, "R3 still waiting on busy", 64'(addr_strobe_n), 64'd1);
        bus_grant_n = 1'b1;
        bus_busy_n = 1'b1;
        dv = '{1'b0, 2'd2, 32'h0ABC_0000, 32'h0, 32'h0F0F_0F0F, 3'd0, 2'd0};
        arb_and_addr(dv, "R3 R4 after busy clears");
        // R9: request offered mid-transfer is ignored
        req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h5555_0000;
        xfer_ack_n = 1'b0; dd_en = 1'b1; dd_val = dv.rdata;
        @(negedge clk);
        req_valid = 1'b0; xfer_ack_n = 1'b1; dd_en = 1'b0;
        chk(rsp_valid && rsp_rdata == dv.rdata, "R9 R8 original read completes",
            64'(rsp_rdata), 64'(dv.rdata));
        repeat (3) begin
            @(negedge clk);
            chk(bus_req_n && req_ready, "R9 no second transfer", 64'({bus_req_n, req_ready}), 64'd3);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule